// File: doc/BRIEF.md
# Watchdog Timer with Selectable Dual-Strobe Clearing

This block is a free-running watchdog counter driven by the slow timing clock. Unless software clears it in time, the counter overflows after 2^CNT_W clock periods. With the default width of 16 and a 32.768 kHz clock, that is about two seconds. On overflow the block issues a one-cycle reset request. Which request it issues depends on the processor's state. When the processor is running, it asks for a full chip reset. When the processor is halted, it asks for a warm reset, which restores only the program counter and stack pointer. Each overflow also raises the time-out flag.

Software clears the counter with one of two schemes, chosen by a static option. In single mode, one clear strobe is enough. In dual mode, two distinct half-strobes must both arrive before the counter clears. A small state machine tracks which halves have been seen. Its states are `ARM_IDLE` (no half seen), `ARM_HAVE_A` (half A seen) and `ARM_HAVE_B` (half B seen). Its transitions are:
- IDLE→HAVE_A on a lone A.
- IDLE→HAVE_B on a lone B.
- Back to IDLE when the pair completes: HAVE_A with B, HAVE_B with A, or IDLE with both in one cycle.
- Back to IDLE on a halt strobe, when the block is disabled, or when single mode is selected.
- Any other input leaves the state as it is.

The halt strobe also clears the counter. It sets the power-down flag and drops the time-out flag. A completed clear instruction drops the power-down flag. A freeze input stops counting while the watchdog clock is stopped during halt. When the enable option is off, the counter is held at zero and the clear strobes do nothing.

Top module: `wdog_guard`

## Requirements
- R1: While and after reset, `rst_req` is 2'b00, `flag_timeout` is 0 and `flag_powerdown` is 0. Counting starts from zero.
- R2: With the block enabled and no clear or freeze, `rst_req` becomes nonzero at the 2^CNT_W-th rising edge after the edge that cleared the counter (or after reset release). After each overflow the count restarts from zero.
- R3: An overflow while `in_halt` is 0 yields `rst_req` = 2'b01 (chip reset) and sets `flag_timeout`.
- R4: An overflow while `in_halt` is 1 yields `rst_req` = 2'b10 (warm reset) and sets `flag_timeout`.
- R5: In single mode (`cfg_dual`=0), a `clr_single` strobe clears the counter and `flag_powerdown`. The `clr_half_a` and `clr_half_b` strobes are ignored.
- R6: In dual mode (`cfg_dual`=1), the counter and `flag_powerdown` clear only once both `clr_half_a` and `clr_half_b` have arrived, in either order or in the same cycle. A lone half, a repeated half of the same kind, and `clr_single` all have no effect.
- R7: In dual mode, the record of seen halves empties when a pair completes or a halt strobe arrives. A single half after that does not clear the counter.
- R8: A `halt_strobe` clears the counter and the half record, sets `flag_powerdown` and clears `flag_timeout`.
- R9: Each edge with `halt_clk_stopped` = 1 leaves the count unchanged, which delays the overflow by that many edges.
- R10: With `cfg_enable` = 0, no overflow ever occurs and the clear strobes leave `flag_powerdown` unchanged. The halt strobe still sets `flag_powerdown`.
- R11: `rst_req` is high for exactly one cycle per overflow and never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog timing clock |
| rst_n | input | 1 | Asynchronous active-low external reset |
| cfg_enable | input | 1 | Static option: watchdog active |
| cfg_dual | input | 1 | Static option: 1 = two-half clearing, 0 = single clearing |
| clr_single | input | 1 | One-cycle single clear strobe |
| clr_half_a | input | 1 | One-cycle first-half clear strobe |
| clr_half_b | input | 1 | One-cycle second-half clear strobe |
| halt_strobe | input | 1 | One-cycle strobe marking execution of halt |
| in_halt | input | 1 | Level: processor is in halt state |
| halt_clk_stopped | input | 1 | Level: watchdog clock gated, freeze count |
| rst_req | output | 2 | Reset request pulse: 01 chip, 10 warm, 00 none |
| flag_timeout | output | 1 | Time-out status flag |
| flag_powerdown | output | 1 | Power-down status flag |

## Verification
All results are registered, so a strobe that is sampled at edge E shows on the flags just after E. An overflow shows on `rst_req` just after the 2^CNT_W-th counting edge that follows the clear, and it drops again one edge later. The bench drives inputs on falling edges and counts rising edges from the clearing edge until `rst_req` goes nonzero. It then compares that count with 2^CNT_W, minus the edges already spent on strobes that should have been ignored and plus any frozen edges. It reads the flags and the request code at the falling edge after the relevant rising edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        ARM_IDLE   = 2'd0,
        ARM_HAVE_A = 2'd1,
        ARM_HAVE_B = 2'd2
    } arm_state_t;

    localparam logic [1:0] RST_NONE = 2'b00;
    localparam logic [1:0] RST_CHIP = 2'b01;
    localparam logic [1:0] RST_WARM = 2'b10;
endpackage

// File: rtl/wdog_clear_fsm.sv
module wdog_clear_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic dual,
    input  logic clr_single,
    input  logic half_a,
    input  logic half_b,
    input  logic wipe,
    output logic clr_cmd
);
    arm_state_t state, state_nx;
    logic       pair_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ARM_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        pair_done = 1'b0;
        state_nx  = state;
        unique case (state)
            ARM_IDLE: begin
                if (half_a && half_b) pair_done = 1'b1;
                else if (half_a)      state_nx  = ARM_HAVE_A;
                else if (half_b)      state_nx  = ARM_HAVE_B;
            end
            ARM_HAVE_A: if (half_b) pair_done = 1'b1;
            ARM_HAVE_B: if (half_a) pair_done = 1'b1;
            default:    state_nx = ARM_IDLE;
        endcase
        if (pair_done || wipe || !enable || !dual) state_nx = ARM_IDLE;
    end

    always_comb begin
        if (!enable) clr_cmd = 1'b0;
        else if (dual) clr_cmd = pair_done;
        else clr_cmd = clr_single;
    end

    // R6
    lone_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && dual && state == ARM_IDLE && (half_a ^ half_b)) |-> !clr_cmd);

    // R7
    record_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmd || wipe) |=> (state == ARM_IDLE));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       clr,
    input  logic       freeze,
    input  logic       in_halt,
    output logic       ovf,
    output logic [1:0] rst_req
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count;

    assign ovf = enable && !clr && !freeze && (count == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count   <= '0;
            rst_req <= RST_NONE;
        end else begin
            if (!enable || clr) count <= '0;
            else if (!freeze)   count <= count + 1'b1;
            if (ovf) rst_req <= in_halt ? RST_WARM : RST_CHIP;
            else     rst_req <= RST_NONE;
        end
    end

    // R11
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req != RST_NONE) |=> (rst_req == RST_NONE));

    // R11
    rst_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req != 2'b11);

    // R9
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && freeze && !clr) |=> $stable(count));

    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (rst_req == RST_NONE));
endmodule

// File: rtl/wdog_status.sv
module wdog_status (
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic clr_cmd,
    input  logic ovf,
    output logic flag_to,
    output logic flag_pdf
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_to  <= 1'b0;
            flag_pdf <= 1'b0;
        end else if (halt) begin
            flag_to  <= 1'b0;
            flag_pdf <= 1'b1;
        end else begin
            if (ovf)     flag_to  <= 1'b1;
            if (clr_cmd) flag_pdf <= 1'b0;
        end
    end

    // R8
    halt_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (flag_pdf && !flag_to));

    // R3
    timeout_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !halt) |=> flag_to);
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_enable,
    input  logic       cfg_dual,
    input  logic       clr_single,
    input  logic       clr_half_a,
    input  logic       clr_half_b,
    input  logic       halt_strobe,
    input  logic       in_halt,
    input  logic       halt_clk_stopped,
    output logic [1:0] rst_req,
    output logic       flag_timeout,
    output logic       flag_powerdown
);
    logic clr_cmd;
    logic clr_any;
    logic ovf;

    assign clr_any = clr_cmd | halt_strobe;

    wdog_clear_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (cfg_enable),
        .dual       (cfg_dual),
        .clr_single (clr_single),
        .half_a     (clr_half_a),
        .half_b     (clr_half_b),
        .wipe       (halt_strobe),
        .clr_cmd    (clr_cmd)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (cfg_enable),
        .clr     (clr_any),
        .freeze  (halt_clk_stopped),
        .in_halt (in_halt),
        .ovf     (ovf),
        .rst_req (rst_req)
    );

    wdog_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt     (halt_strobe),
        .clr_cmd  (clr_cmd),
        .ovf      (ovf),
        .flag_to  (flag_timeout),
        .flag_pdf (flag_powerdown)
    );
endmodule

// File: tb/wdog_guard_tb.sv
module wdog_guard_tb;
    localparam int W     = 6;
    localparam int P     = 1 << W;
    localparam int LIMIT = 4 * P;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 1'b1, cfg_dual = 1'b0;
    logic clr_single = 1'b0, clr_half_a = 1'b0, clr_half_b = 1'b0;
    logic halt_strobe = 1'b0, in_halt = 1'b0, halt_clk_stopped = 1'b0;
    logic [1:0] rst_req;
    logic flag_timeout, flag_powerdown;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wdog_guard #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_dual(cfg_dual),
        .clr_single(clr_single), .clr_half_a(clr_half_a), .clr_half_b(clr_half_b),
        .halt_strobe(halt_strobe), .in_halt(in_halt),
        .halt_clk_stopped(halt_clk_stopped), .rst_req(rst_req),
        .flag_timeout(flag_timeout), .flag_powerdown(flag_powerdown)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic reset_dut(input logic en, input logic dual);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_enable = en; cfg_dual = dual;
        clr_single = 0; clr_half_a = 0; clr_half_b = 0;
        halt_strobe = 0; in_halt = 0; halt_clk_stopped = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // which: 0 single, 1 half A, 2 half B, 3 both halves, 4 halt
    task automatic strobe(input int which);
        case (which)
            0: clr_single = 1'b1;
            1: clr_half_a = 1'b1;
            2: clr_half_b = 1'b1;
            3: begin clr_half_a = 1'b1; clr_half_b = 1'b1; end
            default: halt_strobe = 1'b1;
        endcase
        @(posedge clk);
        @(negedge clk);
        clr_single = 0; clr_half_a = 0; clr_half_b = 0; halt_strobe = 0;
    endtask

    task automatic meas(output int k);
        k = 0;
        while (k < LIMIT) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (rst_req != 2'b00) break;
        end
    endtask

    task automatic test_reset_and_period();
        int k;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_eq("R1 rst_req in reset", int'(rst_req), 0);
        chk_eq("R1 timeout flag in reset", int'(flag_timeout), 0);
        chk_eq("R1 powerdown flag in reset", int'(flag_powerdown), 0);
        reset_dut(1'b1, 1'b0);
        meas(k);
        chk_eq("R2 edges to first overflow", k, P);
        chk_eq("R3 chip reset code", int'(rst_req), 1);
        chk_eq("R3 timeout flag set", int'(flag_timeout), 1);
        idle(1);
        chk_eq("R11 pulse width one cycle", int'(rst_req), 0);
        meas(k);
        chk_eq("R2 period after wrap", k, P - 1);
    endtask

    task automatic test_single();
        int k;
        reset_dut(1'b1, 1'b0);
        strobe(4);
        chk_eq("R8 halt sets powerdown", int'(flag_powerdown), 1);
        idle(5);
        strobe(0);
        chk_eq("R5 single clear drops powerdown", int'(flag_powerdown), 0);
        idle(3);
        strobe(1);
        strobe(2);
        meas(k);
        chk_eq("R5 halves ignored in single mode", k, P - 5);
    endtask

    task automatic test_dual();
        int k;
        reset_dut(1'b1, 1'b1);
        idle(5);
        strobe(1);
        meas(k);
        chk_eq("R6 lone half does not clear", k, P - 6);
        reset_dut(1'b1, 1'b1);
        strobe(4);
        idle(5); strobe(1);
        idle(5); strobe(1);
        idle(5); strobe(0);
        chk_eq("R6 powerdown kept until pair", int'(flag_powerdown), 1);
        strobe(2);
        chk_eq("R6 pair drops powerdown", int'(flag_powerdown), 0);
        meas(k);
        chk_eq("R6 pair A then B clears", k, P);
        reset_dut(1'b1, 1'b1);
        idle(10); strobe(2); idle(2); strobe(1);
        meas(k);
        chk_eq("R6 pair B then A clears", k, P);
        reset_dut(1'b1, 1'b1);
        idle(20); strobe(3);
        meas(k);
        chk_eq("R6 simultaneous pair clears", k, P);
    endtask

    task automatic test_record();
        int k;
        reset_dut(1'b1, 1'b1);
        strobe(1); strobe(2);
        idle(4); strobe(1);
        meas(k);
        chk_eq("R7 record empty after pair", k, P - 5);
        reset_dut(1'b1, 1'b1);
        strobe(1); strobe(4);
        idle(4); strobe(2);
        meas(k);
        chk_eq("R7 halt wipes record", k, P - 5);
    endtask

    task automatic test_halt_timeout();
        int k;
        reset_dut(1'b1, 1'b0);
        meas(k);
        idle(1);
        strobe(4);
        chk_eq("R8 halt clears timeout flag", int'(flag_timeout), 0);
        chk_eq("R8 halt sets powerdown flag", int'(flag_powerdown), 1);
        in_halt = 1'b1;
        meas(k);
        chk_eq("R8 halt clears counter", k, P);
        chk_eq("R4 warm reset code", int'(rst_req), 2);
        chk_eq("R4 timeout flag set in halt", int'(flag_timeout), 1);
        in_halt = 1'b0;
    endtask

    task automatic test_freeze();
        int k;
        reset_dut(1'b1, 1'b0);
        idle(10);
        halt_clk_stopped = 1'b1;
        idle(10);
        halt_clk_stopped = 1'b0;
        meas(k);
        chk_eq("R9 frozen edges delay overflow", k, P + 10 - 20);
    endtask

    task automatic test_disabled();
        int k;
        reset_dut(1'b0, 1'b0);
        meas(k);
        chk_eq("R10 no overflow when disabled", int'(rst_req), 0);
        strobe(4);
        chk_eq("R10 halt still sets powerdown", int'(flag_powerdown), 1);
        strobe(0);
        chk_eq("R10 clear ignored when disabled", int'(flag_powerdown), 1);
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        test_reset_and_period();
        test_single();
        test_dual();
        test_record();
        test_halt_timeout();
        test_freeze();
        test_disabled();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule